// File: doc/BRIEF.md
# ACPI Power Management Register Block

This block is the power-management function of a legacy-style ACPI chipset, reached through a 64-byte I/O window. It holds a free-running power-management timer, a 16-bit status register, a 16-bit enable register and a 16-bit control register. Software polls or clears the status bits. The block raises a level-sensitive system control interrupt (SCI) whenever an enabled status bit is pending.

The timer advances on a clock-enable pulse that a divider elsewhere produces at 3.579545 MHz. The timer itself runs in the block's own clock domain. Each time the count steps onto a multiple of half the timer range, the timer overflow status bit is set.

Writing the sleep command with the soft-off type produces a one-cycle power-off request. A power-button event input sets its status bit when that source is enabled. A separate two-byte APM port holds a command byte and a status byte. Writing certain command values switches the SCI enable bit on or off. Any command write can fire an SMI pulse when an external enable allows it.

Top module: `acpi_pm_block`

## Requirements
- R1: The timer is TMR_W bits wide (default 24). It resets to zero and goes up by one on every clock edge where `tickEn` is high, wrapping at the top of its range. A read at offset 0x08 returns it zero-extended to 32 bits.
- R2: Offset 0x00 reads the status register, 0x02 the enable register and 0x04 the control register. Each value sits in bits 15:0 of `pmRdData` and bits 31:16 read zero. Any other offset, including odd ones, reads zero, and writes to other offsets change nothing.
- R3: Status bit 0 (timer overflow) is set on the clock edge where the timer steps onto a multiple of 2^(TMR_W-1). If software clears bit 0 in that same cycle, the clear wins and the bit stays zero until the next such boundary.
- R4: Status bits are cleared by writing 1 to them at offset 0x00, and bits written as 0 are unchanged. The meaning of each bit is: 0 timer overflow, 5 global, 8 power button, 10 RTC. Hardware sets only bits 0 and 8.
- R5: `sciOut` is high exactly when at least one of bits 0, 5, 8 or 10 is set in both the status and the enable register. It follows register contents in the same cycle they change.
- R6: Control bit 13 (sleep enable) is never stored and always reads 0. A control write with bit 13 set and bits 12:10 equal to 0 drives `powerOffReq` high for exactly the next clock cycle. Any other sleep type gives no request, and the other written bits are stored in every case.
- R7: `pwrBtnEvt` sets status bit 8 only when enable bit 8 held 1 before that clock edge. An event in the same cycle as a write clearing bit 8 leaves the bit set.
- R8: Writing APM command 0xF1 sets control bit 0 (SCI enable) and writing 0xF0 clears it. This overrides a control write to bit 0 in the same cycle, and other command values leave the control register alone.
- R9: `apmSel` picks the APM byte: 0 is the command byte and 1 is the status byte. `apmRdData` returns the last value written to the selected byte, and both bytes reset to 0.
- R10: `smiPulse` is high for exactly the cycle after a command-byte write made while `smiEnable` was high. Status-byte writes never fire it.
- R11: After reset all registers, the timer and every output read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Timer advance enable at the PM timer rate |
| pmWrEn | input | 1 | Write strobe for the register window |
| pmAddr | input | 6 | Byte offset in the 64-byte window |
| pmWrData | input | 16 | Write data for status, enable and control |
| pmRdData | output | 32 | Combinational read data for `pmAddr` |
| apmWrEn | input | 1 | Write strobe for the APM port |
| apmSel | input | 1 | APM byte select: 0 command, 1 status |
| apmWrData | input | 8 | APM write data |
| apmRdData | output | 8 | APM byte selected by `apmSel` |
| smiEnable | input | 1 | Allows command writes to fire an SMI |
| pwrBtnEvt | input | 1 | Power-button event, one cycle per press |
| sciOut | output | 1 | Level SCI interrupt |
| powerOffReq | output | 1 | One-cycle soft-off request |
| smiPulse | output | 1 | One-cycle SMI request |

## Verification
The bench aims at the overflow boundary, so that the overflow status is checked both on the tick that lands on 2^(TMR_W-1) and on the tick just before it. A design with an off-by-one compare would set the bit a tick early or late. It also aims at collisions: a clear in the same cycle as an overflow, and a button press in the same cycle as a clear. A design with the priorities reversed would re-raise or lose the interrupt. Sleep writes of type 0 and of other types show whether bit 13 leaks into storage or fires power-off for the wrong type. APM commands 0xF0, 0xF1 and other values, written together with control writes, expose a wrong override order on the SCI enable bit.

// File: rtl/pmb_pkg.sv
`timescale 1ns/1ps
package pmb_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_STS = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_EN  = 6'h02;
  localparam logic [ADDR_W-1:0] OFS_CTL = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_TMR = 6'h08;

  localparam int BIT_TMROVF = 0;
  localparam int BIT_BTN    = 8;
  localparam int BIT_SLPEN  = 13;
  localparam int BIT_SCIEN  = 0;
  localparam logic [15:0] SCI_MASK = 16'h0521;

  localparam logic [7:0] APM_SCI_ON  = 8'hF1;
  localparam logic [7:0] APM_SCI_OFF = 8'hF0;

  typedef struct packed {
    logic wrSts;
    logic wrEn;
    logic wrCtl;
    logic apmCmdWr;
    logic apmStsWr;
    logic sciOn;
    logic sciOff;
  } pmbStrobes_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STS,
    RD_EN,
    RD_CTL,
    RD_TMR
  } pmbRdSel_t;
endpackage

// File: rtl/pmb_ctrl.sv
`timescale 1ns/1ps
module pmb_ctrl
  import pmb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pmWrEn,
  input  logic [ADDR_W-1:0] pmAddr,
  input  logic [3:0]        sleepField,
  input  logic              apmWrEn,
  input  logic              apmSel,
  input  logic [7:0]        apmWrData,
  input  logic              smiEnable,
  output pmbStrobes_t       strobes,
  output pmbRdSel_t         rdSel,
  output logic              powerOffReq,
  output logic              smiPulse
);
  logic cmdWr;
  logic offNext;

  assign cmdWr = apmWrEn && !apmSel;

  always_comb begin
    strobes          = '0;
    strobes.wrSts    = pmWrEn && (pmAddr == OFS_STS);
    strobes.wrEn     = pmWrEn && (pmAddr == OFS_EN);
    strobes.wrCtl    = pmWrEn && (pmAddr == OFS_CTL);
    strobes.apmCmdWr = cmdWr;
    strobes.apmStsWr = apmWrEn && apmSel;
    strobes.sciOn    = cmdWr && (apmWrData == APM_SCI_ON);
    strobes.sciOff   = cmdWr && (apmWrData == APM_SCI_OFF);
  end

  always_comb begin
    case (pmAddr)
      OFS_STS: rdSel = RD_STS;
      OFS_EN:  rdSel = RD_EN;
      OFS_CTL: rdSel = RD_CTL;
      OFS_TMR: rdSel = RD_TMR;
      default: rdSel = RD_ZERO;
    endcase
  end

  // sleepField = {sleep enable, sleep type[2:0]}
  assign offNext = pmWrEn && (pmAddr == OFS_CTL) && sleepField[3] && (sleepField[2:0] == 3'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerOffReq <= 1'b0;
      smiPulse    <= 1'b0;
    end else begin
      powerOffReq <= offNext;
      smiPulse    <= cmdWr && smiEnable;
    end
  end
endmodule

// File: rtl/pmb_datapath.sv
`timescale 1ns/1ps
module pmb_datapath
  import pmb_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             pwrBtnEvt,
  input  pmbStrobes_t      strobes,
  input  pmbRdSel_t        rdSel,
  input  logic [15:0]      pmWrData,
  input  logic [7:0]       apmWrData,
  input  logic             apmSel,
  output logic [31:0]      pmRdData,
  output logic [7:0]       apmRdData,
  output logic             sciOut,
  output logic [TMR_W-1:0] tmrVal,
  output logic [15:0]      stsVal,
  output logic [15:0]      enVal,
  output logic [15:0]      ctlVal
);
  localparam int OVF_BIT = TMR_W - 1;

  logic [TMR_W-1:0] tmrCnt, tmrInc;
  logic [15:0]      stsReg, stsNext, enReg, ctlReg, ctlNext;
  logic [7:0]       apmCmdReg, apmStsReg;
  logic             atBoundary, ovfClearNow;

  assign tmrInc      = tmrCnt + 1'b1;
  assign atBoundary  = tickEn && (tmrInc[OVF_BIT-1:0] == '0);
  assign ovfClearNow = strobes.wrSts && pmWrData[BIT_TMROVF];

  always_comb begin
    stsNext = stsReg;
    if (strobes.wrSts) stsNext = stsNext & ~pmWrData;
    if (atBoundary && !ovfClearNow) stsNext[BIT_TMROVF] = 1'b1;
    if (pwrBtnEvt && enReg[BIT_BTN]) stsNext[BIT_BTN] = 1'b1;
  end

  always_comb begin
    ctlNext = ctlReg;
    if (strobes.wrCtl) begin
      ctlNext = pmWrData;
      ctlNext[BIT_SLPEN] = 1'b0;
    end
    if (strobes.sciOn)  ctlNext[BIT_SCIEN] = 1'b1;
    if (strobes.sciOff) ctlNext[BIT_SCIEN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrCnt    <= '0;
      stsReg    <= '0;
      enReg     <= '0;
      ctlReg    <= '0;
      apmCmdReg <= '0;
      apmStsReg <= '0;
    end else begin
      if (tickEn) tmrCnt <= tmrInc;
      stsReg <= stsNext;
      ctlReg <= ctlNext;
      if (strobes.wrEn)     enReg     <= pmWrData;
      if (strobes.apmCmdWr) apmCmdReg <= apmWrData;
      if (strobes.apmStsWr) apmStsReg <= apmWrData;
    end
  end

  always_comb begin
    case (rdSel)
      RD_STS:  pmRdData = {16'h0, stsReg};
      RD_EN:   pmRdData = {16'h0, enReg};
      RD_CTL:  pmRdData = {16'h0, ctlReg};
      RD_TMR:  pmRdData = 32'(tmrCnt);
      default: pmRdData = '0;
    endcase
  end

  assign apmRdData = apmSel ? apmStsReg : apmCmdReg;
  assign sciOut    = |(stsReg & enReg & SCI_MASK);

  assign tmrVal = tmrCnt;
  assign stsVal = stsReg;
  assign enVal  = enReg;
  assign ctlVal = ctlReg;
endmodule

// File: rtl/acpi_pm_block.sv
`timescale 1ns/1ps
module acpi_pm_block
  import pmb_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        pmWrEn,
  input  logic [5:0]  pmAddr,
  input  logic [15:0] pmWrData,
  output logic [31:0] pmRdData,
  input  logic        apmWrEn,
  input  logic        apmSel,
  input  logic [7:0]  apmWrData,
  output logic [7:0]  apmRdData,
  input  logic        smiEnable,
  input  logic        pwrBtnEvt,
  output logic        sciOut,
  output logic        powerOffReq,
  output logic        smiPulse
);
  pmbStrobes_t      strobes;
  pmbRdSel_t        rdSel;
  logic [TMR_W-1:0] tmrVal;
  logic [15:0]      stsVal, enVal, ctlVal;

  pmb_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pmWrEn     (pmWrEn),
    .pmAddr     (pmAddr),
    .sleepField (pmWrData[13:10]),
    .apmWrEn    (apmWrEn),
    .apmSel     (apmSel),
    .apmWrData  (apmWrData),
    .smiEnable  (smiEnable),
    .strobes    (strobes),
    .rdSel      (rdSel),
    .powerOffReq(powerOffReq),
    .smiPulse   (smiPulse)
  );

  pmb_datapath #(.TMR_W(TMR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .pwrBtnEvt(pwrBtnEvt),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .pmWrData (pmWrData),
    .apmWrData(apmWrData),
    .apmSel   (apmSel),
    .pmRdData (pmRdData),
    .apmRdData(apmRdData),
    .sciOut   (sciOut),
    .tmrVal   (tmrVal),
    .stsVal   (stsVal),
    .enVal    (enVal),
    .ctlVal   (ctlVal)
  );
endmodule

// File: rtl/acpi_pm_checker.sv
`timescale 1ns/1ps
module acpi_pm_checker #(
  parameter int TMR_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             pmWrEn,
  input logic [5:0]       pmAddr,
  input logic [15:0]      pmWrData,
  input logic             apmWrEn,
  input logic             apmSel,
  input logic [7:0]       apmWrData,
  input logic             smiEnable,
  input logic             pwrBtnEvt,
  input logic             powerOffReq,
  input logic             smiPulse,
  input logic [TMR_W-1:0] tmrVal,
  input logic [15:0]      stsVal,
  input logic [15:0]      enVal,
  input logic [15:0]      ctlVal
);
  p_tmr_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (tmrVal == TMR_W'($past(tmrVal) + 1'b1)));

  p_tmr_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tmrVal));

  p_no_slpen_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctlVal[13]);

  p_off_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |-> $past(pmWrEn && pmAddr == 6'h04 && pmWrData[13] && pmWrData[12:10] == 3'd0));

  p_btn_masked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pwrBtnEvt && !enVal[8] && !stsVal[8]) |=> !stsVal[8]);

  p_apm_on_r8: assert property (@(posedge clk) disable iff (!rstN)
    (apmWrEn && !apmSel && apmWrData == 8'hF1) |=> ctlVal[0]);

  p_apm_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (apmWrEn && !apmSel && apmWrData == 8'hF0) |=> !ctlVal[0]);

  p_smi_cause_r10: assert property (@(posedge clk) disable iff (!rstN)
    smiPulse |-> $past(apmWrEn && !apmSel && smiEnable));
endmodule

bind acpi_pm_block acpi_pm_checker #(.TMR_W(TMR_W)) u_chk (.*);

// File: tb/acpi_pm_block_bench.sv
`timescale 1ns/1ps
module acpi_pm_block_bench;
  localparam int TW = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, pmWrEn = 1'b0, apmWrEn = 1'b0, apmSel = 1'b0;
  logic        smiEnable = 1'b0, pwrBtnEvt = 1'b0;
  logic [5:0]  pmAddr = '0;
  logic [15:0] pmWrData = '0;
  logic [7:0]  apmWrData = '0;
  logic [31:0] pmRdData;
  logic [7:0]  apmRdData;
  logic        sciOut, powerOffReq, smiPulse;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acpi_pm_block #(.TMR_W(TW)) u_acpi_pm_block (.*);

  // reference model, built from the requirements
  logic [TW-1:0] mTmr, mInc;
  logic [15:0]   mSts, mEn, mCtl, sTmp, cTmp;
  logic [7:0]    mCmd, mApmSts;
  logic          mOff, mSmi;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mTmr <= '0; mSts <= '0; mEn <= '0; mCtl <= '0;
      mCmd <= '0; mApmSts <= '0; mOff <= 1'b0; mSmi <= 1'b0;
    end else begin
      mInc = mTmr + 1'b1;
      sTmp = mSts;
      if (pmWrEn && pmAddr == 6'h00) sTmp = sTmp & ~pmWrData;
      if (tickEn && mInc[TW-2:0] == '0 && !(pmWrEn && pmAddr == 6'h00 && pmWrData[0])) sTmp[0] = 1'b1;
      if (pwrBtnEvt && mEn[8]) sTmp[8] = 1'b1;
      cTmp = mCtl;
      if (pmWrEn && pmAddr == 6'h04) cTmp = pmWrData & 16'hDFFF;
      if (apmWrEn && !apmSel && apmWrData == 8'hF1) cTmp[0] = 1'b1;
      if (apmWrEn && !apmSel && apmWrData == 8'hF0) cTmp[0] = 1'b0;
      if (tickEn) mTmr <= mInc;
      mSts <= sTmp;
      mCtl <= cTmp;
      if (pmWrEn && pmAddr == 6'h02) mEn <= pmWrData;
      if (apmWrEn && !apmSel) mCmd <= apmWrData;
      if (apmWrEn && apmSel) mApmSts <= apmWrData;
      mOff <= pmWrEn && pmAddr == 6'h04 && pmWrData[13] && pmWrData[12:10] == 3'd0;
      mSmi <= apmWrEn && !apmSel && smiEnable;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(logic [5:0] a, string req, logic [31:0] exp);
    pmAddr = a;
    #0.1;
    chk(req, pmRdData, exp);
  endtask

  // called just after a falling edge with write strobes low
  task automatic checkAll();
    logic [5:0] other;
    rd(6'h00, "R4 status", {16'h0, mSts});
    rd(6'h02, "R2 enable", {16'h0, mEn});
    rd(6'h04, "R6 control", {16'h0, mCtl});
    rd(6'h08, "R1 timer", 32'(mTmr));
    other = 6'($urandom_range(0, 63));
    if (other == 6'h00 || other == 6'h02 || other == 6'h04 || other == 6'h08) other = 6'h01;
    rd(other, "R2 unmapped", 32'h0);
    apmSel = 1'b0; #0.1; chk("R9 apm cmd", 32'(apmRdData), 32'(mCmd));
    apmSel = 1'b1; #0.1; chk("R9 apm sts", 32'(apmRdData), 32'(mApmSts));
    chk("R5 sci", 32'(sciOut), 32'(|(mSts & mEn & 16'h0521)));
    chk("R6 poweroff", 32'(powerOffReq), 32'(mOff));
    chk("R10 smi", 32'(smiPulse), 32'(mSmi));
  endtask

  task automatic cyc(logic tk, logic we, logic [5:0] a, logic [15:0] d,
                     logic aw, logic as, logic [7:0] ad, logic se, logic btn);
    tickEn = tk; pmWrEn = we; pmAddr = a; pmWrData = d;
    apmWrEn = aw; apmSel = as; apmWrData = ad; smiEnable = se; pwrBtnEvt = btn;
    @(negedge clk);
    pmWrEn = 1'b0; apmWrEn = 1'b0; pwrBtnEvt = 1'b0; tickEn = 1'b0;
    checkAll();
  endtask

  task automatic idle(logic tk);
    cyc(tk, 0, 6'h3F, 16'h0, 0, 0, 8'h0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C1A));
    repeat (3) @(negedge clk);
    // R11: reset values
    rd(6'h00, "R11 status", 32'h0);
    rd(6'h08, "R11 timer", 32'h0);
    chk("R11 sci", 32'(sciOut), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkAll();

    // R3/R5: overflow at the first boundary with enable bit 0 set
    cyc(0, 1, 6'h02, 16'h0101, 0, 0, 8'h0, 0, 0);
    for (int i = 0; i < (1 << (TW-1)) - 1; i++) idle(1);
    rd(6'h00, "R3 before boundary", 32'h0);
    idle(1);
    rd(6'h00, "R3 at boundary", 32'h1);
    chk("R5 sci on overflow", 32'(sciOut), 32'h1);
    // R4: write-1 clear
    cyc(0, 1, 6'h00, 16'h0001, 0, 0, 8'h0, 0, 0);
    rd(6'h00, "R4 cleared", 32'h0);
    // R3: clear in the same cycle as the wrap boundary keeps it clear
    for (int i = 0; i < (1 << (TW-1)) - 1; i++) idle(1);
    cyc(1, 1, 6'h00, 16'h0001, 0, 0, 8'h0, 0, 0);
    rd(6'h08, "R1 wrapped", 32'h0);
    rd(6'h00, "R3 clear wins", 32'h0);
    // R7: button with enable, then masked, then event against clear
    cyc(0, 0, 6'h3F, 16'h0, 0, 0, 8'h0, 0, 1);
    rd(6'h00, "R7 set", 32'h100);
    cyc(0, 1, 6'h00, 16'h0100, 0, 0, 8'h0, 0, 1);
    rd(6'h00, "R7 event wins", 32'h100);
    cyc(0, 1, 6'h02, 16'h0000, 0, 0, 8'h0, 0, 0);
    cyc(0, 1, 6'h00, 16'hFFFF, 0, 0, 8'h0, 0, 0);
    cyc(0, 0, 6'h3F, 16'h0, 0, 0, 8'h0, 0, 1);
    rd(6'h00, "R7 masked", 32'h0);
    // R6: sleep commands
    cyc(0, 1, 6'h04, 16'h2001, 0, 0, 8'h0, 0, 0);
    chk("R6 off pulse", 32'(powerOffReq), 32'h1);
    rd(6'h04, "R6 bit13 dropped", 32'h0001);
    idle(0);
    chk("R6 pulse ends", 32'(powerOffReq), 32'h0);
    cyc(0, 1, 6'h04, 16'h2C00, 0, 0, 8'h0, 0, 0);
    chk("R6 other type", 32'(powerOffReq), 32'h0);
    // R8/R10: APM commands
    cyc(0, 1, 6'h04, 16'h0000, 1, 0, 8'hF1, 1, 0);
    rd(6'h04, "R8 on overrides", 32'h1);
    chk("R10 smi", 32'(smiPulse), 32'h1);
    cyc(0, 0, 6'h3F, 16'h0, 1, 0, 8'h37, 1, 0);
    rd(6'h04, "R8 other value", 32'h1);
    cyc(0, 0, 6'h3F, 16'h0, 1, 1, 8'hA5, 1, 0);
    chk("R10 status no smi", 32'(smiPulse), 32'h0);
    cyc(0, 0, 6'h3F, 16'h0, 1, 0, 8'hF0, 0, 0);
    rd(6'h04, "R8 off", 32'h0);
    chk("R10 smi gated", 32'(smiPulse), 32'h0);
    cyc(0, 1, 6'h21, 16'hFFFF, 0, 0, 8'h0, 0, 0);
    rd(6'h21, "R2 unmapped write", 32'h0);

    // constrained random
    for (int n = 0; n < 6000; n++) begin
      logic [5:0] a; logic [15:0] d; logic [7:0] ad; logic we, aw;
      int pick;
      pick = $urandom_range(0, 5);
      a = (pick == 0) ? 6'h00 : (pick == 1) ? 6'h02 : (pick <= 3) ? 6'h04 : 6'($urandom_range(0, 63));
      d = 16'($urandom);
      if (a == 6'h04 && $urandom_range(0, 1) == 0) d[13:10] = 4'b1000;
      we = ($urandom_range(0, 9) == 0);
      aw = ($urandom_range(0, 11) == 0);
      pick = $urandom_range(0, 2);
      ad = (pick == 0) ? 8'hF1 : (pick == 1) ? 8'hF0 : 8'($urandom);
      cyc(($urandom_range(0, 9) < 8), we, a, d, aw, 1'($urandom_range(0, 1)), ad,
          1'($urandom_range(0, 1)), ($urandom_range(0, 15) == 0));
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule